// File: doc/BRIEF.md
# Rotating-Base Register File

This block is a multi-ported register file for software-pipelined loops. Its register space has two regions. The low region is addressed directly. The high region is addressed through a rotating base: the block adds a base value to every specifier that falls in that region, modulo the region size. A loop-closing branch strobe moves the base down by one. As a result, the same instruction reaches a fresh physical register on each iteration, and a value written as logical N in one iteration is read as logical N+1 in the next. Because of this, producer-to-consumer distances can be encoded as differences between register specifiers.

There are two combinational read ports and one write port, all of which take logical specifiers. A write lands at the clock edge. A read that targets the register being written in the same cycle returns the incoming data. A synchronous load input sets the base, normally to zero at loop entry. All accesses in a cycle use the base as it stood before that cycle's edge.

Top module: `rrf_rotating_regfile`

## Requirements
- R1: A specifier below NUM_STATIC (32) selects physical register equal to the specifier, whatever the base.
- R2: A specifier s at or above NUM_STATIC selects physical register NUM_STATIC + ((s - NUM_STATIC + base) mod NUM_ROT), with NUM_ROT = 96 and base in 0..95.
- R3: Each cycle with loop_br_i high and base_ld_i low lowers the base by one at the clock edge; from 0 it wraps to NUM_ROT-1.
- R4: base_ld_i sets the base to base_val_i mod NUM_ROT at the clock edge and takes priority over loop_br_i in the same cycle.
- R5: After one base decrement, a value written to rotating logical N reads back as logical N+1, including when the base wraps from 0.
- R6: A write in the same cycle as a decrement is placed with the base from before the decrement.
- R7: Reads in a cycle with a pending decrement or load return data mapped with the base from before the edge.
- R8: When wr_en_i is high and a read port resolves to the physical register being written, that port returns wr_data_i in the same cycle.
- R9: Reset (rst_ni low, asynchronous) clears every register to zero and sets the base to 0.
- R10: With wr_en_i low, wr_spec_i and wr_data_i change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write enable |
| wr_spec_i | input | 7 | Logical write specifier |
| wr_data_i | input | 64 | Write data |
| rd_spec_i | input | 2x7 | Logical read specifiers, one per read port |
| rd_data_o | output | 2x64 | Read data, one per read port |
| loop_br_i | input | 1 | Loop-closing branch strobe; decrements the base |
| base_ld_i | input | 1 | Load strobe for the base |
| base_val_i | input | 7 | Value for base load, reduced mod NUM_ROT |

## Verification
A wrong base shows up as a whole rotating region read back shifted. The shift appears on the first read after the faulty edge. To catch it, the bench fills every register with an index-stamped value and reads all 128 specifiers after each of more than NUM_ROT decrements, so a bad wrap or step is seen within one sweep. A misplaced write or a missing forward is visible only on the specific register involved. Targeted same-cycle write/strobe and write/read cases therefore expose these faults in the cycle they occur, or one cycle after.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  typedef enum logic [1:0] {
    BASE_HOLD = 2'd0,
    BASE_DEC  = 2'd1,
    BASE_LOAD = 2'd2
  } base_cmd_e;
endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl
  import rrf_pkg::*;
#(
  parameter int NUM_ROT = 96,
  parameter int BASE_W  = $clog2(NUM_ROT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  base_cmd_e         cmd_i,
  input  logic [BASE_W-1:0] load_val_i,
  output logic [BASE_W-1:0] base_o
);
  localparam logic [BASE_W-1:0] TOP   = BASE_W'(NUM_ROT - 1);
  localparam logic [BASE_W:0]   ROT_X = (BASE_W + 1)'(NUM_ROT);

  logic [BASE_W-1:0] base_q, base_nxt, load_fold;
  logic [BASE_W:0]   load_x;

  // 2**BASE_W < 2*NUM_ROT, so one conditional subtract is a full modulo
  always_comb begin
    load_x    = {1'b0, load_val_i};
    load_fold = (load_x >= ROT_X) ? BASE_W'(load_x - ROT_X) : load_val_i;
  end

  always_comb begin
    unique case (cmd_i)
      BASE_DEC:  base_nxt = (base_q == '0) ? TOP : base_q - 1'b1;
      BASE_LOAD: base_nxt = load_fold;
      default:   base_nxt = base_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else         base_q <= base_nxt;
  end

  assign base_o = base_q;

  a_r3_base_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_q <= TOP);

  a_r3_dec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == BASE_DEC |=>
      base_q == (($past(base_q) == '0) ? TOP : $past(base_q) - 1'b1));

  a_r4_load_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == BASE_LOAD |=>
      (base_q == $past(load_val_i)) || (({1'b0, base_q} + ROT_X) == {1'b0, $past(load_val_i)}));

  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == BASE_HOLD |=> $stable(base_q));
endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
  parameter int NUM_STATIC = 32,
  parameter int NUM_ROT    = 96,
  parameter int SPEC_W     = 7,
  parameter int BASE_W     = 7
) (
  input  logic [SPEC_W-1:0] spec_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [SPEC_W-1:0] phys_o
);
  localparam int SUM_W = SPEC_W + 1;
  localparam logic [SUM_W-1:0] STAT_N = SUM_W'(NUM_STATIC);
  localparam logic [SUM_W-1:0] ROT_N  = SUM_W'(NUM_ROT);

  logic [SUM_W-1:0] spec_x, off, sum, wrapped;

  always_comb begin
    spec_x  = {1'b0, spec_i};
    off     = spec_x - STAT_N;
    sum     = off + SUM_W'(base_i);
    wrapped = (sum >= ROT_N) ? sum - ROT_N : sum;
  end

  generate
    if (NUM_STATIC == 0) begin : g_all_rot
      assign phys_o = SPEC_W'(wrapped);
    end else begin : g_split
      assign phys_o = (spec_x < STAT_N) ? spec_i : SPEC_W'(wrapped + STAT_N);
    end
  endgenerate
endmodule

// File: rtl/rrf_store.sv
module rrf_store #(
  parameter int NUM_REGS = 128,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int NUM_RD   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              waddr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  raddr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  generate
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rdata_o[p] = mem_q[raddr_i[p]];
    end
  endgenerate

  a_r6_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

  a_r10_idle_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> mem_q[$past(waddr_i)] == $past(mem_q[waddr_i]));
endmodule

// File: rtl/rrf_rotating_regfile.sv
module rrf_rotating_regfile
  import rrf_pkg::*;
#(
  parameter int NUM_STATIC = 32,
  parameter int NUM_ROT    = 96,
  parameter int DATA_W     = 64,
  parameter int NUM_RD     = 2,
  localparam int NUM_REGS  = NUM_STATIC + NUM_ROT,
  localparam int SPEC_W    = $clog2(NUM_REGS),
  localparam int BASE_W    = $clog2(NUM_ROT)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [SPEC_W-1:0]              wr_spec_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic [NUM_RD-1:0][SPEC_W-1:0]  rd_spec_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o,
  input  logic                           loop_br_i,
  input  logic                           base_ld_i,
  input  logic [BASE_W-1:0]              base_val_i
);
  localparam logic [SPEC_W:0] STAT_X = (SPEC_W + 1)'(NUM_STATIC);
  localparam logic [SPEC_W:0] REGS_X = (SPEC_W + 1)'(NUM_REGS);

  base_cmd_e                       base_cmd;
  logic [BASE_W-1:0]               base;
  logic [SPEC_W-1:0]               wr_phys;
  logic [NUM_RD-1:0][SPEC_W-1:0]   rd_phys;
  logic [NUM_RD-1:0][DATA_W-1:0]   store_rdata;

  // load wins over the branch strobe
  always_comb begin
    if (base_ld_i)      base_cmd = BASE_LOAD;
    else if (loop_br_i) base_cmd = BASE_DEC;
    else                base_cmd = BASE_HOLD;
  end

  rrf_base_ctrl #(.NUM_ROT(NUM_ROT), .BASE_W(BASE_W)) u_base (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (base_cmd),
    .load_val_i (base_val_i),
    .base_o     (base)
  );

  // all maps see the pre-edge base, so writes and reads in a strobe cycle use the old mapping
  rrf_map #(.NUM_STATIC(NUM_STATIC), .NUM_ROT(NUM_ROT), .SPEC_W(SPEC_W), .BASE_W(BASE_W)) u_wr_map (
    .spec_i (wr_spec_i),
    .base_i (base),
    .phys_o (wr_phys)
  );

  rrf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(SPEC_W), .NUM_RD(NUM_RD)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .waddr_i (wr_phys),
    .wdata_i (wr_data_i),
    .raddr_i (rd_phys),
    .rdata_o (store_rdata)
  );

  generate
    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
      rrf_map #(.NUM_STATIC(NUM_STATIC), .NUM_ROT(NUM_ROT), .SPEC_W(SPEC_W), .BASE_W(BASE_W)) u_rd_map (
        .spec_i (rd_spec_i[p]),
        .base_i (base),
        .phys_o (rd_phys[p])
      );

      assign rd_data_o[p] = (wr_en_i && (wr_phys == rd_phys[p])) ? wr_data_i : store_rdata[p];

      a_r1_static_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, rd_spec_i[p]} < STAT_X) |-> rd_phys[p] == rd_spec_i[p]);

      a_r2_stays_in_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, rd_spec_i[p]} >= STAT_X) |->
          ({1'b0, rd_phys[p]} >= STAT_X) && ({1'b0, rd_phys[p]} < REGS_X));

      a_r8_same_spec_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_spec_i == rd_spec_i[p])) |-> rd_data_o[p] == wr_data_i);
    end
  endgenerate
endmodule

// File: tb/rrf_rotating_regfile_bench.sv
module rrf_rotating_regfile_bench;
  localparam int NS = 32;
  localparam int NR = 96;
  localparam int NT = NS + NR;
  localparam int DW = 64;
  localparam int SW = 7;
  localparam int BW = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst_ni;
  logic                   wr_en;
  logic [SW-1:0]          wr_spec;
  logic [DW-1:0]          wr_data;
  logic [1:0][SW-1:0]     rd_spec;
  logic [1:0][DW-1:0]     rd_data;
  logic                   loop_br;
  logic                   base_ld;
  logic [BW-1:0]          base_val;

  rrf_rotating_regfile u_rrf_rotating_regfile (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_spec_i  (wr_spec),
    .wr_data_i  (wr_data),
    .rd_spec_i  (rd_spec),
    .rd_data_o  (rd_data),
    .loop_br_i  (loop_br),
    .base_ld_i  (base_ld),
    .base_val_i (base_val)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] ref_mem [NT];
  int ref_base;

  function automatic int map_ref(int s, int b);
    if (s < NS) return s;
    return NS + ((s - NS + b) % NR);
  endfunction

  function automatic logic [DW-1:0] dv(int i, int k);
    return {8'hD5, 8'(k), 8'(i), 8'hE1, 32'(i * 32'h9E3779B1 + k)};
  endfunction

  function automatic logic [DW-1:0] exp_rd(int rs, bit we, int ws, logic [DW-1:0] wd);
    int ph;
    ph = map_ref(rs, ref_base);
    if (we && map_ref(ws, ref_base) == ph) return wd;
    return ref_mem[ph];
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_ref();
    for (int i = 0; i < NT; i++) ref_mem[i] = '0;
    ref_base = 0;
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic op(bit we, int ws, logic [DW-1:0] wd, bit lb, bit ld, int lv,
                    int r0, int r1, string req);
    wr_en = we; wr_spec = SW'(ws); wr_data = wd;
    loop_br = lb; base_ld = ld; base_val = BW'(lv);
    rd_spec[0] = SW'(r0); rd_spec[1] = SW'(r1);
    #1;
    if (req != "") begin
      chk(req, rd_data[0], exp_rd(r0, we, ws, wd));
      chk(req, rd_data[1], exp_rd(r1, we, ws, wd));
    end
    @(posedge clk);
    if (we) ref_mem[map_ref(ws, ref_base)] = wd;
    if (ld)      ref_base = lv % NR;
    else if (lb) ref_base = (ref_base + NR - 1) % NR;
    @(negedge clk);
    #0;
  endtask

  task automatic peek(int r0, int r1);
    wr_en = 1'b0; loop_br = 1'b0; base_ld = 1'b0;
    rd_spec[0] = SW'(r0); rd_spec[1] = SW'(r1);
    #1;
  endtask

  task automatic read_all(string rs, string rr);
    for (int s = 0; s < NT; s += 2)
      op(0, 0, '0, 0, 0, 0, s, s + 1, (s < NS) ? rs : rr);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wr_en = 1'b0; loop_br = 1'b0; base_ld = 1'b0;
    wr_spec = '0; wr_data = '0; base_val = '0; rd_spec = '0;
    repeat (2) @(negedge clk);
    clear_ref();
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_ni = 1'b0;
    clear_ref();
    do_reset();

    // R9: everything reads zero after reset
    read_all("R9", "R9");
    // R9: base starts at 0 -> write at logical 32 lands at physical 32
    op(1, 32, 64'h0000_0000_0000_0B0B, 0, 0, 0, 0, 1, "");
    op(0, 0, '0, 0, 1, 0, 0, 1, "");
    peek(32, 0);
    chk("R9", rd_data[0], 64'h0000_0000_0000_0B0B);
    @(negedge clk);

    // fill every register at base 0
    for (int i = 0; i < NT; i++) op(1, i, dv(i, 0), 0, 0, 0, 0, 1, "");
    read_all("R1", "R2");
    op(0, 0, '0, 0, 1, 17, 0, 1, "");
    read_all("R1", "R2");

    // R3: step the base past a full wrap, sweep all specifiers each time
    for (int k = 0; k < NR + 2; k++) begin
      op(0, 0, '0, 1, 0, 0, 0, 1, "");
      read_all("R1", "R3");
    end

    // R4: out-of-range load folds (127 -> 31), load beats strobe
    op(0, 0, '0, 1, 1, 127, 0, 1, "");
    read_all("R4", "R4");
    op(0, 0, '0, 0, 1, 95, 0, 1, "");
    read_all("R4", "R4");

    // R5: logical N written, read as N+1 after one strobe
    op(0, 0, '0, 0, 1, 5, 0, 1, "");
    op(1, 40, 64'h5555_0000_0000_0040, 0, 0, 0, 0, 1, "");
    op(0, 0, '0, 1, 0, 0, 0, 1, "");
    peek(41, 40);
    chk("R5", rd_data[0], 64'h5555_0000_0000_0040);
    @(negedge clk);
    // R5: same with base wrapping 0 -> 95
    op(0, 0, '0, 0, 1, 0, 0, 1, "");
    op(1, 32, 64'h5555_0000_0000_0032, 0, 0, 0, 0, 1, "");
    op(0, 0, '0, 1, 0, 0, 0, 1, "");
    peek(33, 32);
    chk("R5", rd_data[0], 64'h5555_0000_0000_0032);
    @(negedge clk);

    // R6: write coinciding with strobe uses old base
    op(0, 0, '0, 0, 1, 10, 0, 1, "");
    op(1, 70, 64'h6666_0000_0000_0070, 1, 0, 0, 0, 1, "");
    peek(71, 70);
    chk("R6", rd_data[0], 64'h6666_0000_0000_0070);
    chk("R6", rd_data[1], ref_mem[map_ref(70, ref_base)]);
    @(negedge clk);

    // R7: reads during strobe / load cycles see the old mapping
    op(0, 0, '0, 1, 0, 0, 71, 100, "R7");
    op(0, 0, '0, 0, 1, 60, 45, 127, "R7");
    op(0, 0, '0, 1, 1, 3, 33, 90, "R7");

    // R8: same-cycle write and read of one register
    op(1, 50, 64'h8888_0000_0000_0050, 0, 0, 0, 50, 3, "R8");
    op(1, 3, 64'h8888_0000_0000_0003, 0, 0, 0, 3, 50, "R8");
    op(1, 100, 64'h8888_0000_0000_0100, 1, 0, 0, 100, 101, "R8");

    // R10: disabled write leaves target untouched
    op(0, 0, '0, 0, 1, 0, 0, 1, "");
    op(1, 50, 64'h8888_0000_0000_0A50, 0, 0, 0, 0, 1, "");
    op(0, 50, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 0, 50, 3, "R10");
    peek(50, 3);
    chk("R10", rd_data[0], 64'h8888_0000_0000_0A50);
    chk("R10", rd_data[1], 64'h8888_0000_0000_0003);
    @(negedge clk);

    // R9: asynchronous reset mid-run clears state again
    op(0, 0, '0, 0, 1, 44, 0, 1, "");
    do_reset();
    read_all("R9", "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule